// File: doc/BRIEF.md
# Eight-Pin GPIO Port with Snapshot-Based Change Interrupt

The block is an eight-bit general-purpose I/O port reached through a small register bus. Each pin has a bit in an output latch and a bit in a direction register. A direction bit of 1 makes the pin an input and turns its driver off. A direction bit of 0 drives the latched value onto the pin. One active-low control bit turns on weak pull-ups on every pin together. The pull-up of a pin that is set as an output is always off.

Pin inputs pass through a two-flop synchronizer. The four upper pins can raise a change interrupt. The reference for comparison is not the previous clock's value. Each participating pin is compared with a snapshot taken at the most recent access to the port register. When any unmasked upper input differs from its snapshot, a small two-state flag machine moves from `FLG_IDLE` to `FLG_PEND`. That flag drives `irq_flag`, and together with the raw mismatch it drives `wake_req`, so a sleeping system can be woken. The machine returns from `FLG_PEND` to `FLG_IDLE` only when software clears the flag while no mismatch is present. Software ends a mismatch by reading or writing the port register, which refreshes the snapshot.

Top module: `gpio_chg_port`

## Requirements
- R1: After reset the direction register reads 8'hFF, the output latch and snapshot are 0, the control register reads 8'h01 (pull-ups disabled, flag clear), and `pin_oe`, `pin_out`, `pin_pu` and `irq_flag` are all 0.
- R2: Register address 0 is the port, 1 is direction, 2 is control. A write to address 1 sets direction, and `pin_oe[i]` is the inverse of direction bit i. A write to address 0 sets the output latch, which appears on `pin_out`.
- R3: Control bit 0 is an active-low pull-up enable. `pin_pu[i]` is 1 exactly when control bit 0 is 0 and direction bit i is 1.
- R4: A read of address 0 returns `pin_in` delayed by two clock edges of synchronization.
- R5: A synchronized difference between an upper input pin (bits 7..4) and its snapshot sets the flag (control bit 1). Changes on bits 3..0 never set it.
- R6: An upper pin whose direction bit is 0 is excluded from the comparison.
- R7: Writing 0 to control bit 1 clears the flag. If a mismatch is present in the same cycle, the flag stays set.
- R8: Any read or write of address 0 loads the snapshot with the synchronized pins and ends the mismatch, after which a clear takes effect.
- R9: `wake_req` is high whenever the flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| pin_in | input | 8 | Pin input levels |
| pin_out | output | 8 | Output latch to pads |
| pin_oe | output | 8 | Pad driver enables |
| pin_pu | output | 8 | Pad weak pull-up enables |
| irq_flag | output | 1 | Change interrupt flag |
| wake_req | output | 1 | Wake request |

## Verification
Directed patterns test a change on a lower pin only, which must not set the flag, and a change on an upper pin set as an output, which must be masked. A persistent upper mismatch separates a set-wins clear from a plain clear. Refreshing the snapshot shows that a port access, and not the passage of time, ends the mismatch. Random direction masks and pin values, each preceded by a snapshot refresh, compare the flag with a bench model of the masked XOR over the upper nibble. A random write phase checks the output-enable and pull-up gating across direction and pull-up settings.

// File: rtl/gpio_chg_pkg.sv
package gpio_chg_pkg;
    typedef enum logic [1:0] {
        REG_PORT = 2'd0,
        REG_DIR  = 2'd1,
        REG_CTRL = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;

    typedef enum logic {
        FLG_IDLE = 1'b0,
        FLG_PEND = 1'b1
    } flg_state_e;

    localparam int CTRL_PU_BIT   = 0;
    localparam int CTRL_FLAG_BIT = 1;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= din;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[g] <= '0;
            else        stage_q[g] <= stage_q[g-1];
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_lat,
    input  logic         wr_dir,
    input  logic         wr_ctrl,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] lat_q,
    output logic [W-1:0] dir_q,
    output logic         pu_n_q,
    output logic [W-1:0] pu_en
);
    import gpio_chg_pkg::*;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_q  <= '0;
            dir_q  <= '1;
            pu_n_q <= 1'b1;
        end else begin
            if (wr_lat)  lat_q  <= wdata;
            if (wr_dir)  dir_q  <= wdata;
            if (wr_ctrl) pu_n_q <= wdata[CTRL_PU_BIT];
        end
    end

    assign pu_en = dir_q & {W{~pu_n_q}};
endmodule

// File: rtl/gpio_chg_det.sv
module gpio_chg_det #(
    parameter int W      = 8,
    parameter int CHG_LO = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sync_in,
    input  logic [W-1:0] dir_q,
    input  logic         port_acc,
    input  logic         flag_clr,
    output logic [W-1:0] snap_q,
    output logic         mismatch,
    output logic         flag
);
    import gpio_chg_pkg::*;

    localparam logic [W-1:0] CHG_MASK = {W{1'b1}} << CHG_LO;

    flg_state_e   state_q, state_d;
    logic [W-1:0] diff;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        snap_q <= '0;
        else if (port_acc) snap_q <= sync_in;
    end

    assign diff     = (sync_in ^ snap_q) & dir_q & CHG_MASK;
    assign mismatch = (|diff) & ~port_acc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLG_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLG_IDLE: if (mismatch)              state_d = FLG_PEND;
            FLG_PEND: if (!mismatch && flag_clr) state_d = FLG_IDLE;
            default:                             state_d = FLG_IDLE;
        endcase
    end

    always_comb begin
        flag = (state_q == FLG_PEND);
    end
endmodule

// File: rtl/gpio_chg_port.sv
module gpio_chg_port #(
    parameter int WIDTH       = 8,
    parameter int CHG_LO      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [1:0]       bus_addr,
    input  logic [WIDTH-1:0] bus_wdata,
    output logic [WIDTH-1:0] bus_rdata,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] pin_out,
    output logic [WIDTH-1:0] pin_oe,
    output logic [WIDTH-1:0] pin_pu,
    output logic             irq_flag,
    output logic             wake_req
);
    import gpio_chg_pkg::*;

    reg_sel_e         rsel;
    logic             port_acc, wr_lat, wr_dir, wr_ctrl, flag_clr;
    logic             mismatch, pu_n_q;
    logic [WIDTH-1:0] sync_q, lat_q, dir_q, snap_q;

    assign rsel     = reg_sel_e'(bus_addr);
    assign port_acc = bus_sel & (bus_wr | bus_rd) & (rsel == REG_PORT);
    assign wr_lat   = bus_sel & bus_wr & (rsel == REG_PORT);
    assign wr_dir   = bus_sel & bus_wr & (rsel == REG_DIR);
    assign wr_ctrl  = bus_sel & bus_wr & (rsel == REG_CTRL);
    assign flag_clr = wr_ctrl & ~bus_wdata[CTRL_FLAG_BIT];

    gpio_sync #(.W(WIDTH), .STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .din(pin_in), .dout(sync_q)
    );

    gpio_regs #(.W(WIDTH)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_lat(wr_lat), .wr_dir(wr_dir),
        .wr_ctrl(wr_ctrl), .wdata(bus_wdata), .lat_q(lat_q),
        .dir_q(dir_q), .pu_n_q(pu_n_q), .pu_en(pin_pu)
    );

    gpio_chg_det #(.W(WIDTH), .CHG_LO(CHG_LO)) det_i (
        .clk(clk), .rst_n(rst_n), .sync_in(sync_q), .dir_q(dir_q),
        .port_acc(port_acc), .flag_clr(flag_clr), .snap_q(snap_q),
        .mismatch(mismatch), .flag(irq_flag)
    );

    assign pin_out  = lat_q;
    assign pin_oe   = ~dir_q;
    assign wake_req = irq_flag | mismatch;

    always_comb begin
        bus_rdata = '0;
        unique case (rsel)
            REG_PORT: bus_rdata = sync_q;
            REG_DIR:  bus_rdata = dir_q;
            REG_CTRL: begin
                bus_rdata[CTRL_PU_BIT]   = pu_n_q;
                bus_rdata[CTRL_FLAG_BIT] = irq_flag;
            end
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_chg_port_chk.sv
module gpio_chg_port_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_sel,
    input logic             bus_wr,
    input logic [1:0]       bus_addr,
    input logic [WIDTH-1:0] bus_wdata,
    input logic [WIDTH-1:0] pin_oe,
    input logic [WIDTH-1:0] pin_pu,
    input logic             irq_flag,
    input logic             wake_req,
    input logic             mismatch,
    input logic             port_acc,
    input logic [WIDTH-1:0] snap_q,
    input logic [WIDTH-1:0] sync_q
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (!irq_flag && pin_oe == '0));

    assert_dir_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == 2'd1) |=> pin_oe == ~$past(bus_wdata));

    assert_pu_only_inputs_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_pu & pin_oe) == '0);

    assert_mismatch_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mismatch |=> irq_flag);

    assert_clear_works_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == 2'd2 && !bus_wdata[1] && !mismatch)
        |=> !irq_flag);

    assert_snapshot_refresh_R8: assert property (@(posedge clk) disable iff (!rst_n)
        port_acc |=> snap_q == $past(sync_q));

    assert_wake_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_flag |-> wake_req);
endmodule

bind gpio_chg_port gpio_chg_port_chk #(.WIDTH(WIDTH)) chk_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .pin_oe(pin_oe),
    .pin_pu(pin_pu), .irq_flag(irq_flag), .wake_req(wake_req),
    .mismatch(mismatch), .port_acc(port_acc), .snap_q(snap_q),
    .sync_q(sync_q)
);

// File: tb/gpio_chg_port_tb_top.sv
`timescale 1ns/1ps
module gpio_chg_port_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata, pin_in = 8'h00, pin_out, pin_oe, pin_pu;
    logic       irq_flag, wake_req;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    logic [7:0] m_dir = 8'hFF, m_snap = 8'h00;
    logic       m_pun = 1'b1;

    always #2.5 clk = ~clk;

    gpio_chg_port dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .pin_pu(pin_pu), .irq_flag(irq_flag),
        .wake_req(wake_req)
    );

    function automatic logic [7:0] exp_pu(logic [7:0] d, logic pun);
        return pun ? 8'h00 : d;
    endfunction

    function automatic logic exp_mis(logic [7:0] p, logic [7:0] s, logic [7:0] d);
        return |((p ^ s) & d & 8'hF0);
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic wait_cyc(int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        int seed;
        seed = $urandom(32'h5EED);
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);

        // R1: reset state
        bus_read(2'd1, rd);  check("R1 dir", rd, 8'hFF);
        bus_read(2'd2, rd);  check("R1 ctrl", rd, 8'h01);
        check("R1 oe", pin_oe, 8'h00);
        check("R1 pu", pin_pu, 8'h00);
        check("R1 out", pin_out, 8'h00);
        check("R1 flag", {7'd0, irq_flag}, 8'h00);

        // R2 R3: random register writes
        for (int i = 0; i < 40; i++) begin
            logic [7:0] d, l;
            logic p;
            d = 8'($urandom); l = 8'($urandom); p = 1'($urandom);
            bus_write(2'd1, d);
            bus_write(2'd0, l);
            bus_write(2'd2, {6'd0, 1'b1, p});
            m_dir = d; m_pun = p;
            check("R2 oe", pin_oe, ~d);
            check("R2 out", pin_out, l);
            check("R3 pu", pin_pu, exp_pu(d, p));
        end
        // the port writes refreshed the snapshot; restore all-input and clear
        bus_write(2'd1, 8'hFF); m_dir = 8'hFF;
        pin_in = 8'h00; wait_cyc(3);
        bus_read(2'd0, rd); m_snap = 8'h00;
        bus_write(2'd2, {6'd0, 1'b0, m_pun});
        check("R8 clear after refresh", {7'd0, irq_flag}, 8'h00);

        // R4: two-edge synchronizer latency
        @(negedge clk); pin_in = 8'h3C;
        @(posedge clk);
        bus_read(2'd0, rd); check("R4 one edge", rd, 8'h00);
        bus_read(2'd0, rd); check("R4 two edges", rd, 8'h3C);
        m_snap = 8'h3C;
        bus_write(2'd2, {6'd0, 1'b0, m_pun});

        // R5: lower pins never set the flag
        pin_in = 8'h3C ^ 8'h0F; wait_cyc(4);
        check("R5 lower pins", {7'd0, irq_flag}, 8'h00);
        // R5: upper pin sets flag, R9 wake
        pin_in = pin_in ^ 8'h40; wait_cyc(4);
        check("R5 upper pin", {7'd0, irq_flag}, 8'h01);
        check("R9 wake", {7'd0, wake_req}, 8'h01);
        // R7: clear while mismatch persists -> set wins
        bus_write(2'd2, {6'd0, 1'b0, m_pun});
        check("R7 set wins", {7'd0, irq_flag}, 8'h01);
        // R8: port read refreshes, then clear succeeds
        bus_read(2'd0, rd); m_snap = rd;
        bus_write(2'd2, {6'd0, 1'b0, m_pun});
        check("R8 refresh then clear", {7'd0, irq_flag}, 8'h00);
        check("R7 clear", {7'd0, wake_req}, 8'h00);

        // R6: upper pin as output is masked
        bus_write(2'd1, 8'h7F); m_dir = 8'h7F;
        pin_in = m_snap ^ 8'h80; wait_cyc(4);
        check("R6 masked output", {7'd0, irq_flag}, 8'h00);
        // R8: port write also refreshes
        bus_write(2'd1, 8'hFF); m_dir = 8'hFF;
        wait_cyc(1);
        check("R6 unmasked", {7'd0, irq_flag}, 8'h01);
        bus_write(2'd0, 8'hAA);
        bus_write(2'd2, {6'd0, 1'b0, m_pun});
        check("R8 write refresh", {7'd0, irq_flag}, 8'h00);

        // R5 R6: random direction masks and pin changes
        for (int i = 0; i < 60; i++) begin
            logic [7:0] d, p0, p1;
            d = 8'($urandom); p0 = 8'($urandom); p1 = 8'($urandom);
            bus_write(2'd1, d); m_dir = d;
            pin_in = p0; wait_cyc(3);
            bus_read(2'd0, rd); m_snap = p0;
            check("R4 random read", rd, p0);
            bus_write(2'd2, {6'd0, 1'b0, m_pun});
            check("R8 random clear", {7'd0, irq_flag}, 8'h00);
            pin_in = p1; wait_cyc(4);
            check("R5 R6 random flag", {7'd0, irq_flag},
                  {7'd0, exp_mis(p1, m_snap, m_dir)});
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule